// File: doc/BRIEF.md
# Display Controller Write-Only I2C Target with Control-Byte Routing

This block is the serial front end of a display controller. It watches a two-wire I2C bus and detects START and STOP conditions. It accepts write transfers aimed at its own 7-bit address, whose least significant bit comes from a strap input. It acknowledges each byte by pulling the data line low, which is modelled here as an output enable. Both bus lines pass through a two-flop synchroniser and a stability filter before any edge is decoded.

After an accepted address, the payload is framed by control bytes. Bit 7 of a control byte is the continuation flag. When it is set, exactly one payload byte follows and then another control byte is expected. When it is clear, every byte up to the next START or STOP is payload of one kind. Bit 6 of the control byte selects the kind of payload: 1 sends the bytes to the display-data strobe and 0 sends them to the command strobe. Each display-data byte is tagged with a column pointer. The pointer then advances by one and wraps to zero after the last column.

Top module: `i2cs_disp_sink`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 0111100 with bit 1 replaced by `addr_sel_i`, and whose bit 0 (direction) is 0. The address is therefore 0x3C or 0x3D, and the byte on the wire is 0x78 or 0x7A. The acknowledge is `sda_pull_o` high throughout the high phase of the ninth clock, and the pull is raised only while SCL is low.
- R2: On an address mismatch, or when the direction bit is 1, the block does not acknowledge that byte or any later byte, and it produces no strobes until the next START.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP, bytes clocked without a new START are neither acknowledged nor routed.
- R4: Once an address has been accepted, every later byte of the transfer is acknowledged in its ninth clock.
- R5: The first payload byte after the address is a control byte. Only bit 7 (continuation) and bit 6 (data/command) are decoded, and bits 5..0 have no effect.
- R6: A control byte with bit 7 = 0 makes every following byte, up to START or STOP, a payload byte of the selected kind, even if its value looks like a control byte.
- R7: A control byte with bit 7 = 1 makes exactly one following byte a payload byte. The byte after that is parsed as a control byte.
- R8: A payload byte with bit 6 = 1 pulses `pix_vld_o` for one cycle with the byte on `pix_byte_o`. With bit 6 = 0 it pulses `cmd_vld_o` with the byte on `cmd_byte_o`. The two strobes are never high together.
- R9: `col_ptr_o` is 0 after reset. While `pix_vld_o` is high, `col_ptr_o` shows the column being written. The pointer moves only after a display-data strobe: it advances by one and wraps from COLS-1 to 0. Command bytes leave it unchanged.
- R10: A repeated START returns the block to address matching, and the first payload byte after the new address is again parsed as a control byte.
- R11: A pulse on SCL shorter than FILT system clocks is ignored and does not shift a bit.
- R12: After a synchronous reset (`rst_n` low), `sda_pull_o`, `cmd_vld_o` and `pix_vld_o` are low and `col_ptr_o` is 0, even when the reset arrives in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 1 | Strap that sets bit 0 of the 7-bit address |
| sda_pull_o | output | 1 | High pulls the data line low (open-drain enable) |
| cmd_vld_o | output | 1 | One-cycle command byte strobe |
| cmd_byte_o | output | 8 | Command byte |
| pix_vld_o | output | 1 | One-cycle display-data strobe |
| pix_byte_o | output | 8 | Display-data byte |
| col_ptr_o | output | $clog2(COLS) | Column of the current or next display-data write |

## Verification
Two things can land in the same cycle. The first is the display-data strobe for the last column together with the column pointer wrapping back to zero. The bench provokes this by streaming more data bytes than the column count, with COLS set small, and checks the reported column of each strobe against a modulo model. The second is a repeated START arriving while the block is inside a payload stream, which resets the control-byte parser. It is judged by sending a byte that would be display data under the old framing and confirming that no strobe results, then confirming that the following byte is routed as a command.

// File: rtl/i2cs_pkg.sv
// Shared constants and state types for the display I2C write target.
// Assumes 8-bit bytes; control-byte flag positions are fixed by protocol.
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int CO_BIT = 7;   // continuation flag in a control byte
    localparam int DC_BIT = 6;   // data (1) / command (0) flag

    typedef enum logic [1:0] {E_IDLE, E_ADDR, E_DATA, E_SKIP} eng_state_t;
    typedef enum logic [1:0] {M_CTRL, M_ONE, M_STREAM} route_mode_t;
endpackage

// File: rtl/i2cs_line_filter.sv
// Synchronises one bus line and passes a new level only after FILT
// consecutive equal samples. Assumes the line idles high (reset value 1).
module i2cs_line_filter #(
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [1:0]      sync_q;
    logic [FILT-1:0] hist_q;

    // Two-flop synchroniser followed by a sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            hist_q <= {hist_q[FILT-2:0], sync_q[1]};
        end
    end

    // Output follows only a fully stable history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_o <= 1'b1;
        else if (&hist_q)
            line_o <= 1'b1;
        else if (~|hist_q)
            line_o <= 1'b0;
    end
endmodule

// File: rtl/i2cs_bit_engine.sv
// Decodes START/STOP and SCL edges from the filtered lines, assembles
// bytes, matches the address and drives the acknowledge pull.
// Assumes write-only use; a read request is treated as a mismatch.
module i2cs_bit_engine
    import i2cs_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b011110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic              addr_sel_i,
    output logic              sda_pull_o,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              bus_evt_o
);
    logic              scl_q, sda_q;
    logic              start_p, stop_p, rise, fall;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-2:0] shreg_q;
    logic [BYTE_W-1:0] next_byte;
    logic              full_q, in_ack_q, addr_ok;
    eng_state_t        state_q;

    // Bus condition and edge decode.
    always_comb begin
        start_p   = scl_f & scl_q & sda_q & ~sda_f;
        stop_p    = scl_f & scl_q & ~sda_q & sda_f;
        rise      = scl_f & ~scl_q;
        fall      = ~scl_f & scl_q;
        next_byte = {shreg_q, sda_f};
        addr_ok   = (next_byte[BYTE_W-1:1] == {ADDR_HI, addr_sel_i}) && !next_byte[0];
        bus_evt_o = start_p | stop_p;
    end

    // Transfer state, bit shifting and acknowledge control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1; sda_q <= 1'b1;
            state_q <= E_IDLE; cnt_q <= '0; shreg_q <= '0;
            full_q <= 1'b0; in_ack_q <= 1'b0;
            sda_pull_o <= 1'b0; byte_vld_o <= 1'b0; byte_o <= '0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            byte_vld_o <= 1'b0;
            if (start_p || stop_p) begin
                state_q <= start_p ? E_ADDR : E_IDLE;
                cnt_q <= '0; full_q <= 1'b0; in_ack_q <= 1'b0;
                sda_pull_o <= 1'b0;
            end else if (state_q == E_ADDR || state_q == E_DATA) begin
                if (rise && !in_ack_q && !full_q) begin
                    shreg_q <= next_byte[BYTE_W-2:0];
                    cnt_q   <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(BYTE_W-1)) begin
                        cnt_q <= '0;
                        if (state_q == E_ADDR) begin
                            if (addr_ok) full_q <= 1'b1;
                            else         state_q <= E_SKIP;
                        end else begin
                            full_q     <= 1'b1;
                            byte_vld_o <= 1'b1;
                            byte_o     <= next_byte;
                        end
                    end
                end else if (fall && full_q) begin
                    full_q <= 1'b0; in_ack_q <= 1'b1; sda_pull_o <= 1'b1;
                    if (state_q == E_ADDR) state_q <= E_DATA;
                end else if (fall && in_ack_q) begin
                    in_ack_q <= 1'b0; sda_pull_o <= 1'b0;
                end
            end
        end
    end

    // R1
    ack_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_f);
    // R2
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == E_SKIP) |-> (!sda_pull_o && !byte_vld_o));
    // R3
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (!sda_pull_o && state_q == E_IDLE));
endmodule

// File: rtl/i2cs_ctrl_router.sv
// Parses control bytes and routes payload bytes to the command or the
// display-data strobe; keeps the wrapping column pointer.
// Assumes restart_i pulses on every START and STOP.
module i2cs_ctrl_router
    import i2cs_pkg::*;
#(
    parameter int COLS  = 128,
    parameter int COL_W = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              cmd_vld_o,
    output logic [BYTE_W-1:0] cmd_byte_o,
    output logic              pix_vld_o,
    output logic [BYTE_W-1:0] pix_byte_o,
    output logic [COL_W-1:0]  col_ptr_o
);
    route_mode_t mode_q;
    logic        dc_q;

    // Control-byte framing and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_CTRL; dc_q <= 1'b0;
            cmd_vld_o <= 1'b0; cmd_byte_o <= '0;
            pix_vld_o <= 1'b0; pix_byte_o <= '0;
        end else begin
            cmd_vld_o <= 1'b0;
            pix_vld_o <= 1'b0;
            if (restart_i) begin
                mode_q <= M_CTRL;
            end else if (byte_vld_i) begin
                if (mode_q == M_CTRL) begin
                    dc_q   <= byte_i[DC_BIT];
                    mode_q <= byte_i[CO_BIT] ? M_ONE : M_STREAM;
                end else begin
                    if (dc_q) begin
                        pix_vld_o <= 1'b1; pix_byte_o <= byte_i;
                    end else begin
                        cmd_vld_o <= 1'b1; cmd_byte_o <= byte_i;
                    end
                    if (mode_q == M_ONE) mode_q <= M_CTRL;
                end
            end
        end
    end

    // Column pointer advances after each display-data strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            col_ptr_o <= '0;
        else if (pix_vld_o)
            col_ptr_o <= (col_ptr_o == COL_W'(COLS-1)) ? '0 : col_ptr_o + 1'b1;
    end

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_vld_o, pix_vld_o}));
    // R9
    col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pix_vld_o) |-> $stable(col_ptr_o));
    // R7
    single_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_ONE && byte_vld_i && !restart_i) |=> (mode_q == M_CTRL));
    // R6
    stream_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_STREAM && byte_vld_i && !restart_i) |=> (mode_q == M_STREAM));
endmodule

// File: rtl/i2cs_disp_sink.sv
// Top of the display I2C write target: line filters, bit engine and
// control-byte router. Assumes clk runs well above SCL (several FILT
// periods per SCL phase).
module i2cs_disp_sink
    import i2cs_pkg::*;
#(
    parameter int         COLS    = 128,
    parameter int         FILT    = 3,
    parameter logic [5:0] ADDR_HI = 6'b011110,
    localparam int        COL_W   = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel_i,
    output logic              sda_pull_o,
    output logic              cmd_vld_o,
    output logic [BYTE_W-1:0] cmd_byte_o,
    output logic              pix_vld_o,
    output logic [BYTE_W-1:0] pix_byte_o,
    output logic [COL_W-1:0]  col_ptr_o
);
    logic [1:0]        raw_w, filt_w;
    logic              byte_vld, bus_evt;
    logic [BYTE_W-1:0] byte_w;

    assign raw_w = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2cs_line_filter #(.FILT(FILT)) u_filt (
            .clk(clk), .rst_n(rst_n), .line_i(raw_w[g]), .line_o(filt_w[g]));
    end

    i2cs_bit_engine #(.ADDR_HI(ADDR_HI)) u_eng (
        .clk(clk), .rst_n(rst_n), .scl_f(filt_w[1]), .sda_f(filt_w[0]),
        .addr_sel_i(addr_sel_i), .sda_pull_o(sda_pull_o),
        .byte_vld_o(byte_vld), .byte_o(byte_w), .bus_evt_o(bus_evt));

    i2cs_ctrl_router #(.COLS(COLS), .COL_W(COL_W)) u_rtr (
        .clk(clk), .rst_n(rst_n), .restart_i(bus_evt),
        .byte_vld_i(byte_vld), .byte_i(byte_w),
        .cmd_vld_o(cmd_vld_o), .cmd_byte_o(cmd_byte_o),
        .pix_vld_o(pix_vld_o), .pix_byte_o(pix_byte_o), .col_ptr_o(col_ptr_o));
endmodule

// File: tb/i2cs_disp_sink_bench.sv
module i2cs_disp_sink_bench;
    localparam int BCOLS = 6;
    localparam int H = 20;
    localparam int Q = 10;

    typedef struct packed {
        logic       strap;
        logic [7:0] addr;
        logic [7:0] ctrl;
        logic [7:0] dat;
        logic       ack;
        logic [1:0] kind;   // 0 none, 1 command, 2 display data
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{1'b0, 8'h78, 8'h80, 8'hAF, 1'b1, 2'd1},
        '{1'b0, 8'h78, 8'hC0, 8'h5A, 1'b1, 2'd2},
        '{1'b1, 8'h7A, 8'h40, 8'h3C, 1'b1, 2'd2},
        '{1'b1, 8'h7A, 8'h3F, 8'h81, 1'b1, 2'd1},
        '{1'b0, 8'h7A, 8'h80, 8'h11, 1'b0, 2'd0},
        '{1'b0, 8'h79, 8'hC0, 8'h22, 1'b0, 2'd0},
        '{1'b1, 8'h78, 8'h80, 8'h33, 1'b0, 2'd0}
    };

    logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1, strap = 0;
    logic sda_pull, cmd_vld, pix_vld, sda_line;
    logic [7:0] cmd_byte, pix_byte;
    logic [$clog2(BCOLS)-1:0] col_ptr;
    int checks = 0, errors = 0;
    int cmd_cnt = 0, pix_cnt = 0, exp_cmd = 0, exp_pix = 0, exp_col = 0;
    int cmd_last = 0, pix_last = 0, pix_col = 0;
    logic acked;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    i2cs_disp_sink #(.COLS(BCOLS)) u_i2cs_disp_sink (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel_i(strap), .sda_pull_o(sda_pull),
        .cmd_vld_o(cmd_vld), .cmd_byte_o(cmd_byte),
        .pix_vld_o(pix_vld), .pix_byte_o(pix_byte), .col_ptr_o(col_ptr));

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmd_vld) begin cmd_cnt++; cmd_last = cmd_byte; end
        if (rst_n && pix_vld) begin pix_cnt++; pix_last = pix_byte; pix_col = col_ptr; end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    task automatic wclk(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic i2c_start();
        sda_m = 1; wclk(Q); scl_m = 1; wclk(H); sda_m = 0; wclk(H); scl_m = 0; wclk(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 0; wclk(Q); scl_m = 1; wclk(H); sda_m = 1; wclk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ak);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wclk(Q); scl_m = 1; wclk(H); scl_m = 0; wclk(Q);
        end
        sda_m = 1; wclk(Q); scl_m = 1; wclk(H/2);
        ak = !sda_line;
        wclk(H/2); scl_m = 0; wclk(Q);
    endtask

    task automatic glitch();
        scl_m = 1; wclk(2); scl_m = 0; wclk(Q);
    endtask

    task automatic want_cmd(input logic [7:0] b, input string req);
        exp_cmd++;
        chk(cmd_cnt == exp_cmd && pix_cnt == exp_pix, req, cmd_cnt, exp_cmd);
        chk(cmd_last == b, req, cmd_last, b);
    endtask

    task automatic want_pix(input logic [7:0] b, input string req);
        exp_pix++;
        chk(pix_cnt == exp_pix && cmd_cnt == exp_cmd, req, pix_cnt, exp_pix);
        chk(pix_last == b, req, pix_last, b);
        chk(pix_col == exp_col, {req, " column"}, pix_col, exp_col);
        exp_col = (exp_col + 1) % BCOLS;
    endtask

    task automatic want_none(input string req);
        chk(cmd_cnt == exp_cmd && pix_cnt == exp_pix, req, cmd_cnt + pix_cnt, exp_cmd + exp_pix);
    endtask

    task automatic want_ack(input logic exp, input string req);
        chk(acked == exp, req, acked, exp);
    endtask

    initial begin
        wclk(6);
        // R12: reset state
        chk(!sda_pull && !cmd_vld && !pix_vld, "R12 reset outputs", sda_pull, 0);
        chk(col_ptr == 0, "R12 reset column", col_ptr, 0);
        rst_n = 1; wclk(10);

        // Vector table: address match, strap, direction, routing (R1 R2 R5 R8)
        for (int v = 0; v < 7; v++) begin
            strap = VEC[v].strap; wclk(4);
            i2c_start();
            send_byte(VEC[v].addr, acked); want_ack(VEC[v].ack, "R1 address ack");
            send_byte(VEC[v].ctrl, acked); want_ack(VEC[v].ack, "R4 control ack");
            send_byte(VEC[v].dat, acked);  want_ack(VEC[v].ack, "R4 payload ack");
            case (VEC[v].kind)
                2'd1:    want_cmd(VEC[v].dat, "R8 command route");
                2'd2:    want_pix(VEC[v].dat, "R8 data route");
                default: want_none("R2 ignored transfer");
            endcase
            i2c_stop();
        end
        strap = 0; wclk(4);

        // R7 and R5: single-byte framing alternates with control bytes
        i2c_start();
        send_byte(8'h78, acked); want_ack(1, "R1 ack");
        send_byte(8'h80, acked); send_byte(8'hAE, acked); want_cmd(8'hAE, "R7 one command");
        send_byte(8'hC0, acked); send_byte(8'h55, acked); want_pix(8'h55, "R7 one data");
        send_byte(8'hBF, acked); want_none("R5 control not routed");
        send_byte(8'h12, acked); want_cmd(8'h12, "R5 low bits ignored");
        i2c_stop();

        // R6 and R9: data stream past the column count, pointer wraps
        i2c_start();
        send_byte(8'h78, acked); send_byte(8'h40, acked);
        for (int k = 0; k < 8; k++) begin
            send_byte(8'h10 + 8'(k), acked);
            want_ack(1, "R4 stream ack");
            want_pix(8'h10 + 8'(k), "R9 stream data");
        end
        chk(col_ptr == exp_col, "R9 pointer after wrap", col_ptr, exp_col);
        i2c_stop();

        // R6: command stream, control-looking bytes stay commands
        i2c_start();
        send_byte(8'h78, acked); send_byte(8'h00, acked);
        send_byte(8'h40, acked); want_cmd(8'h40, "R6 command stream");
        send_byte(8'h80, acked); want_cmd(8'h80, "R6 command stream");
        send_byte(8'hC0, acked); want_cmd(8'hC0, "R6 command stream");
        chk(col_ptr == exp_col, "R9 commands hold pointer", col_ptr, exp_col);
        i2c_stop();

        // R10: repeated START inside a data stream
        i2c_start();
        send_byte(8'h78, acked); send_byte(8'h40, acked);
        send_byte(8'h11, acked); want_pix(8'h11, "R10 before restart");
        i2c_start();
        send_byte(8'h78, acked); want_ack(1, "R10 readdress ack");
        send_byte(8'h00, acked); want_none("R10 control parsed again");
        send_byte(8'h22, acked); want_cmd(8'h22, "R10 command after restart");
        i2c_stop();

        // R3: bytes after STOP without START are ignored
        send_byte(8'h40, acked); want_ack(0, "R3 no ack after stop");
        send_byte(8'h66, acked); want_ack(0, "R3 no ack after stop");
        want_none("R3 no strobes after stop");
        i2c_start();
        send_byte(8'h78, acked); send_byte(8'hC0, acked);
        send_byte(8'h77, acked); want_pix(8'h77, "R3 recovery");
        i2c_stop();

        // R11: short SCL pulse between bytes does not shift a bit
        i2c_start();
        send_byte(8'h78, acked); send_byte(8'h40, acked);
        glitch();
        send_byte(8'h3C, acked); want_ack(1, "R11 ack after glitch");
        want_pix(8'h3C, "R11 glitch ignored");
        i2c_stop();

        // R12: reset in the middle of a transfer
        i2c_start();
        send_byte(8'h78, acked); send_byte(8'h40, acked);
        send_byte(8'h01, acked); want_pix(8'h01, "R12 before reset");
        rst_n = 0; wclk(4);
        chk(col_ptr == 0 && !sda_pull, "R12 mid reset", col_ptr, 0);
        rst_n = 1; exp_col = 0; wclk(10);
        i2c_stop();
        i2c_start();
        send_byte(8'h78, acked); send_byte(8'hC0, acked);
        send_byte(8'h99, acked); want_pix(8'h99, "R12 column restarts");
        i2c_stop();

        summary();
    end
endmodule